// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the operand offset and the 20-bit physical address for a 16-bit processor with segmented memory. It receives a decoded addressing form, the two base registers (BX, BP), the two index registers (SI, DI), a sign-extended displacement and the three data-side segment registers (DS, SS, ES).

It adds the terms that the form selects, modulo 2^16, to produce the effective address (EA). It then picks a segment from the base register in use, or from an override input. The physical address is the segment value shifted left by four plus the EA.

The two string forms supply the source pointer (SI in the data segment) and the destination pointer (DI in the extra segment). A request strobe captures the inputs, and the registered result appears one cycle later with a one-cycle valid pulse.

Top module: `ea_gen_top`

## Requirements
- R1: After synchronous reset, `valid` is 0 and `ea`, `seg_code` and `pa` are all zero.
- R2: Form code 000 (direct) gives EA = `disp`, with the data segment as the default.
- R3: Form code 001 (pointer) gives EA = SI when `ptr_sel`=00, DI when 01, and BX when 10 or 11, with the data segment as the default.
- R4: Form code 010 (based) gives EA = base + `disp`. The base is BX when `base_sel`=0, with the data segment as default, and BP when `base_sel`=1, with the stack segment as default.
- R5: Form code 011 (indexed) gives EA = index + `disp`, with the index SI when `index_sel`=0 and DI when 1, and the data segment as default.
- R6: Form code 100 gives EA = base + index, and `disp` is ignored. Form code 101 gives EA = base + index + `disp`. In both forms the default segment follows the base as in R4.
- R7: Form code 110 (string source) gives EA = SI with the data segment as default. Form code 111 (string destination) gives EA = DI in the extra segment, and `ovr_valid` has no effect on it.
- R8: Segment codes are 00 = data (DS), 01 = stack (SS), 10 = extra (ES), and 11 = data (DS, reported as 00). When `ovr_valid`=1, `ovr_code` replaces the default segment for every form except 111.
- R9: The EA sum wraps modulo 2^16. `pa` = (segment value × 16 + EA) modulo 2^20.
- R10: The outputs load on the clock edge where `req`=1. `valid` is high for exactly the following cycle, and outputs hold while `req`=0. Back-to-back requests give one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, captures all operand inputs |
| form | input | 3 | Addressing form code |
| base_sel | input | 1 | 0 = BX, 1 = BP |
| index_sel | input | 1 | 0 = SI, 1 = DI |
| ptr_sel | input | 2 | Pointer choice for form 001 |
| disp | input | 16 | Sign-extended displacement or direct offset |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base pointer BP |
| reg_si | input | 16 | Source index SI |
| reg_di | input | 16 | Destination index DI |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_es | input | 16 | Extra segment value |
| ovr_valid | input | 1 | Segment override present |
| ovr_code | input | 2 | Override segment code |
| valid | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| seg_code | output | 2 | Segment used |
| pa | output | 20 | Physical address |

## Verification
Every form is driven with distinct register values, so that picking the wrong base, index or pointer gives a different EA. Each form is also driven with a nonzero displacement, so that adding the displacement when it should be left out (or leaving it out when it should be added) shows up.

The BX and BP variants use different DS and SS values, which separates the two default segments. Overrides are applied to a based form and to both string forms, which shows that the string destination is exempt and that code 11 maps to the data segment.

A wrap case overflows both the 16-bit EA sum and the 20-bit physical sum. Single, spaced and back-to-back requests check the valid pulse and the holding of the outputs.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int OFS_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = OFS_W + SEG_SHIFT;

    typedef enum logic [2:0] {
        FORM_DIRECT  = 3'd0,
        FORM_PTR     = 3'd1,
        FORM_BASED   = 3'd2,
        FORM_INDEXED = 3'd3,
        FORM_BI      = 3'd4,
        FORM_BI_DISP = 3'd5,
        FORM_STR_SRC = 3'd6,
        FORM_STR_DST = 3'd7
    } ea_form_e;

    typedef enum logic [1:0] {
        SEG_DATA  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_RSVD  = 2'd3
    } seg_code_e;

    typedef struct packed {
        logic [OFS_W-1:0] ea;
        seg_code_e        seg;
        logic [PA_W-1:0]  pa;
    } ea_result_t;

    function automatic logic [PA_W-1:0] phys_addr(input logic [OFS_W-1:0] segv,
                                                  input logic [OFS_W-1:0] ofs);
        return {segv, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ofs};
    endfunction
endpackage

// File: rtl/ea_offset.sv
module ea_offset
    import ea_pkg::*;
#(
    parameter int W = OFS_W
) (
    input  ea_form_e       form,
    input  logic           base_sel,
    input  logic           index_sel,
    input  logic [1:0]     ptr_sel,
    input  logic [W-1:0]   disp,
    input  logic [W-1:0]   reg_bx,
    input  logic [W-1:0]   reg_bp,
    input  logic [W-1:0]   reg_si,
    input  logic [W-1:0]   reg_di,
    output logic [W-1:0]   ea
);
    logic [W-1:0] base_v, idx_v, ptr_v;
    logic [W-1:0] term_a, term_b, term_c;

    always_comb begin
        base_v = base_sel  ? reg_bp : reg_bx;
        idx_v  = index_sel ? reg_di : reg_si;
        case (ptr_sel)
            2'b00:   ptr_v = reg_si;
            2'b01:   ptr_v = reg_di;
            default: ptr_v = reg_bx;
        endcase
    end

    always_comb begin
        term_a = '0;
        term_b = '0;
        term_c = '0;
        unique case (form)
            FORM_DIRECT:  term_c = disp;
            FORM_PTR:     term_a = ptr_v;
            FORM_BASED:   begin term_a = base_v; term_c = disp; end
            FORM_INDEXED: begin term_b = idx_v;  term_c = disp; end
            FORM_BI:      begin term_a = base_v; term_b = idx_v; end
            FORM_BI_DISP: begin term_a = base_v; term_b = idx_v; term_c = disp; end
            FORM_STR_SRC: term_b = reg_si;
            FORM_STR_DST: term_b = reg_di;
            default:      term_c = '0;
        endcase
        ea = term_a + term_b + term_c;
    end
endmodule

// File: rtl/ea_segsel.sv
module ea_segsel
    import ea_pkg::*;
(
    input  ea_form_e   form,
    input  logic       base_sel,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_code,
    output seg_code_e  seg
);
    seg_code_e dflt;
    seg_code_e ovr;

    always_comb begin
        case (form)
            FORM_BASED, FORM_BI, FORM_BI_DISP:
                dflt = base_sel ? SEG_STACK : SEG_DATA;
            FORM_STR_DST:
                dflt = SEG_EXTRA;
            default:
                dflt = SEG_DATA;
        endcase
        ovr = (ovr_code == 2'd3) ? SEG_DATA : seg_code_e'(ovr_code);
        seg = (ovr_valid && form != FORM_STR_DST) ? ovr : dflt;
    end
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top
    import ea_pkg::*;
#(
    parameter int W   = OFS_W,
    parameter int PAW = PA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req,
    input  logic [2:0]     form,
    input  logic           base_sel,
    input  logic           index_sel,
    input  logic [1:0]     ptr_sel,
    input  logic [W-1:0]   disp,
    input  logic [W-1:0]   reg_bx,
    input  logic [W-1:0]   reg_bp,
    input  logic [W-1:0]   reg_si,
    input  logic [W-1:0]   reg_di,
    input  logic [W-1:0]   seg_ds,
    input  logic [W-1:0]   seg_ss,
    input  logic [W-1:0]   seg_es,
    input  logic           ovr_valid,
    input  logic [1:0]     ovr_code,
    output logic           valid,
    output logic [W-1:0]   ea,
    output logic [1:0]     seg_code,
    output logic [PAW-1:0] pa
);
    ea_form_e     form_e;
    logic [W-1:0] ea_nx;
    seg_code_e    seg_nx;
    logic [W-1:0] segv;
    ea_result_t   res_q;
    logic         valid_q;

    assign form_e = ea_form_e'(form);

    ea_offset #(.W(W)) u_ofs (
        .form(form_e), .base_sel(base_sel), .index_sel(index_sel),
        .ptr_sel(ptr_sel), .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp),
        .reg_si(reg_si), .reg_di(reg_di), .ea(ea_nx)
    );

    ea_segsel u_seg (
        .form(form_e), .base_sel(base_sel), .ovr_valid(ovr_valid),
        .ovr_code(ovr_code), .seg(seg_nx)
    );

    always_comb begin
        case (seg_nx)
            SEG_STACK: segv = seg_ss;
            SEG_EXTRA: segv = seg_es;
            default:   segv = seg_ds;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req;
            if (req) begin
                res_q.ea  <= ea_nx;
                res_q.seg <= seg_nx;
                res_q.pa  <= phys_addr(segv, ea_nx);
            end
        end
    end

    assign valid    = valid_q;
    assign ea       = res_q.ea;
    assign seg_code = res_q.seg;
    assign pa       = res_q.pa;

    assert_valid_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        req |=> valid);
    assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
        !req |=> !valid);
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(ea) && $stable(pa) && $stable(seg_code)));
    assert_strdst_extra_R7: assert property (@(posedge clk) disable iff (rst)
        (req && form == 3'd7) |=> (seg_code == 2'd2 && ea == $past(reg_di)));
    assert_bp_stack_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !ovr_valid && form == 3'd2 && base_sel) |=> seg_code == 2'd1);
    assert_no_rsvd_code_R8: assert property (@(posedge clk) disable iff (rst)
        valid |-> seg_code != 2'd3);
endmodule

// File: tb/tb_ea_gen_top.sv
module tb_ea_gen_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [2:0]  form;
    logic        base_sel, index_sel;
    logic [1:0]  ptr_sel;
    logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di, seg_ds, seg_ss, seg_es;
    logic        ovr_valid;
    logic [1:0]  ovr_code;
    logic        valid;
    logic [15:0] ea;
    logic [1:0]  seg_code;
    logic [19:0] pa;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [15:0] ea;
        logic [1:0]  seg;
        logic [19:0] pa;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    ea_gen_top dut (
        .clk(clk), .rst(rst), .req(req), .form(form), .base_sel(base_sel),
        .index_sel(index_sel), .ptr_sel(ptr_sel), .disp(disp),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_es(seg_es),
        .ovr_valid(ovr_valid), .ovr_code(ovr_code),
        .valid(valid), .ea(ea), .seg_code(seg_code), .pa(pa)
    );

    function automatic exp_t model(string tag);
        exp_t e;
        logic [15:0] b, x, p, sv;
        logic [1:0]  s;
        b = base_sel ? reg_bp : reg_bx;
        x = index_sel ? reg_di : reg_si;
        p = (ptr_sel == 2'b00) ? reg_si : (ptr_sel == 2'b01) ? reg_di : reg_bx;
        s = 2'd0;
        case (form)
            3'd0: e.ea = disp;
            3'd1: e.ea = p;
            3'd2: begin e.ea = b + disp; s = base_sel ? 2'd1 : 2'd0; end
            3'd3: e.ea = x + disp;
            3'd4: begin e.ea = b + x; s = base_sel ? 2'd1 : 2'd0; end
            3'd5: begin e.ea = b + x + disp; s = base_sel ? 2'd1 : 2'd0; end
            3'd6: e.ea = reg_si;
            default: begin e.ea = reg_di; s = 2'd2; end
        endcase
        if (ovr_valid && form != 3'd7) s = (ovr_code == 2'd3) ? 2'd0 : ovr_code;
        sv = (s == 2'd1) ? seg_ss : (s == 2'd2) ? seg_es : seg_ds;
        e.seg = s;
        e.pa  = 20'({sv, 4'h0} + {4'h0, e.ea});
        e.tag = tag;
        return e;
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    // driver: applies one request at a negedge, leaves req high
    task automatic issue(input logic [2:0] f, input logic bs, input logic is,
                         input logic [1:0] ps, input logic [15:0] d,
                         input logic ov, input logic [1:0] oc, input string tag);
        @(negedge clk);
        form = f; base_sel = bs; index_sel = is; ptr_sel = ps; disp = d;
        ovr_valid = ov; ovr_code = oc; req = 1'b1;
        sb.push_back(model(tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 valid with no pending request", 32'(valid), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(ea == e.ea, {e.tag, " ea"}, 32'(ea), 32'(e.ea));
                check(seg_code == e.seg, {e.tag, " seg"}, 32'(seg_code), 32'(e.seg));
                check(pa == e.pa, {e.tag, " pa"}, 32'(pa), 32'(e.pa));
            end
        end
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] hold_ea;
        rst = 1'b1; req = 1'b0; form = 3'd0; base_sel = 1'b0; index_sel = 1'b0;
        ptr_sel = 2'd0; disp = 16'h0; ovr_valid = 1'b0; ovr_code = 2'd0;
        reg_bx = 16'h1100; reg_bp = 16'h2200; reg_si = 16'h0330; reg_di = 16'h0440;
        seg_ds = 16'h1000; seg_ss = 16'h2000; seg_es = 16'h3000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(valid == 1'b0, "R1 valid after reset", 32'(valid), 32'd0);
        check(ea == 16'h0 && pa == 20'h0 && seg_code == 2'd0, "R1 outputs after reset",
              32'(pa), 32'd0);

        issue(3'd0, 0, 0, 0, 16'h1234, 0, 0, "R2 direct");
        issue(3'd1, 0, 0, 2'd0, 16'h0005, 0, 0, "R3 ptr SI");
        issue(3'd1, 0, 0, 2'd1, 16'h0005, 0, 0, "R3 ptr DI");
        issue(3'd1, 0, 0, 2'd2, 16'h0005, 0, 0, "R3 ptr BX");
        issue(3'd1, 0, 0, 2'd3, 16'h0005, 0, 0, "R3 ptr BX code3");
        issue(3'd2, 0, 0, 0, 16'h0010, 0, 0, "R4 based BX");
        issue(3'd2, 1, 0, 0, 16'h0010, 0, 0, "R4 based BP");
        issue(3'd3, 0, 1, 0, 16'hFFFE, 0, 0, "R5 indexed DI neg disp");
        issue(3'd3, 0, 0, 0, 16'h0007, 0, 0, "R5 indexed SI");
        issue(3'd4, 1, 0, 0, 16'h0777, 0, 0, "R6 BP+SI disp ignored");
        issue(3'd5, 0, 1, 0, 16'h0020, 0, 0, "R6 BX+DI+disp");
        issue(3'd6, 0, 0, 0, 16'h0099, 0, 0, "R7 string source");
        issue(3'd7, 0, 0, 0, 16'h0099, 1, 2'd1, "R7 string dest override ignored");
        issue(3'd6, 0, 0, 0, 16'h0000, 1, 2'd2, "R8 override on string source");
        issue(3'd2, 1, 0, 0, 16'h0004, 1, 2'd2, "R8 override BP to ES");
        issue(3'd4, 1, 1, 0, 16'h0000, 1, 2'd3, "R8 code 3 maps to DS");
        idle(1);
        hold_ea = ea;
        idle(3);
        check(valid == 1'b0, "R10 valid single pulse", 32'(valid), 32'd0);
        check(ea == hold_ea, "R10 outputs hold while idle", 32'(ea), 32'(hold_ea));

        reg_bx = 16'hFFF0; reg_si = 16'h0020; seg_ds = 16'hFFFF;
        issue(3'd5, 0, 0, 0, 16'h0010, 0, 0, "R9 ea and pa wrap");
        idle(1);
        reg_bp = 16'h8000; reg_di = 16'h8001; seg_ss = 16'hF000;
        issue(3'd4, 1, 1, 0, 16'h0000, 0, 0, "R9 ea wrap BP+DI");
        idle(3);
        check(sb.size() == 0, "R10 all results delivered", 32'(sb.size()), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule